// File: doc/BRIEF.md
# Receive Frame Header Validator

This block watches a received Ethernet frame as it streams past on a 64-bit beat bus and decides, at the end of the frame, whether the frame belongs to the single configured connection. It classifies the frame as address resolution (ARP), IPv4 carrying TCP, or something else. It then checks the Ethernet, IP and TCP address and port fields against the local and peer settings, applies structural rules to the IPv4 and TCP headers, and recomputes both the IPv4 header checksum and the TCP checksum (pseudo-header included). Finally it range-checks the sequence and acknowledgment numbers against the receive window and the unacknowledged send span.

It sits in front of a payload store. One cycle after the last beat of each frame it presents a verdict pulse with the accept bit, the frame kind and the byte offset where TCP payload begins. The store uses these to keep or drop the bytes it has captured. The block holds no payload and does no reordering.

Frame bytes are big-endian on the bus: byte 0 of a beat is on bits 63:56. On the last beat, `in_empty` gives the number of unused low-order bytes.

Top module: `rx_hdr_validator`

## Requirements
- R1: `out_valid` is high for exactly the one cycle after each beat that carries `in_last`, and low at all other times; after reset `out_valid` and `out_accept` are 0.
- R2: A TCP frame is accepted only if its destination MAC equals the local MAC, its source MAC equals the peer MAC, its source and destination IP (bytes 26-29, 30-33) equal the peer and local IP, and its source and destination port (bytes 34-35, 36-37) equal the peer and local port.
- R3: Frame kind (`out_type`) is 1 for EtherType 0x0806, 2 for EtherType 0x0800 with protocol byte 23 equal to 6, and 0 otherwise; kind 0 is always rejected. An ARP frame is accepted when hardware type is 1, protocol type 0x0800, address lengths 6 and 4, operation 1 or 2, destination MAC local or all-ones, sender IP (bytes 28-31) equal to the peer IP, target IP (bytes 38-41) equal to the local IP, and the frame is at least 42 bytes.
- R4: An IPv4 frame is rejected unless byte 14 is 0x45. It is also rejected if the more-fragments bit (bit 13 of bytes 20-21) is set or the fragment offset (bits 12:0) is nonzero. The don't-fragment bit alone does not cause rejection.
- R5: The TCP header length nibble (byte 46 bits 7:4) must be 5 to 15, and the TCP header must fit in the segment. The IPv4 total length (bytes 16-17) must be at least 40, and the frame must carry at least 14 + total length bytes. Bytes beyond that are padding and are ignored.
- R6: The one's-complement sum of IPv4 header bytes 14-33, folded to 16 bits, must be 0xFFFF.
- R7: The folded one's-complement sum of the pseudo-header (source IP, destination IP, protocol 6, TCP length) plus the TCP segment must be 0xFFFF. An odd-length segment is padded with one zero byte.
- R8: The frame is rejected unless ((seq - `rcv_next`) mod 2^32) + payload length ≤ `rcv_wnd`, where payload length = total length - 20 - TCP header bytes.
- R9: The frame is rejected unless ((ack - `snd_una`) mod 2^32) ≤ ((`snd_next` - `snd_una`) mod 2^32).
- R10: A frame whose last beat carries `in_crc_err` is rejected; the next frame is judged on its own.
- R11: `out_pay_off` is 34 + 4 × header-length nibble for a TCP frame and 0 for other kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat present |
| in_data | input | 64 | Beat bytes, first byte on bits 63:56 |
| in_last | input | 1 | Final beat of frame |
| in_empty | input | 3 | Unused low-order bytes on the final beat |
| in_crc_err | input | 1 | Frame check failure, valid with in_last |
| cfg_local_mac | input | 48 | Own MAC address |
| cfg_peer_mac | input | 48 | Remote MAC address |
| cfg_local_ip | input | 32 | Own IPv4 address |
| cfg_peer_ip | input | 32 | Remote IPv4 address |
| cfg_local_port | input | 16 | Own TCP port |
| cfg_peer_port | input | 16 | Remote TCP port |
| rcv_next | input | 32 | Next expected receive sequence number |
| rcv_wnd | input | 32 | Receive window size in bytes |
| snd_una | input | 32 | Oldest unacknowledged send sequence |
| snd_next | input | 32 | Next send sequence |
| out_valid | output | 1 | Verdict pulse |
| out_accept | output | 1 | Frame accepted |
| out_type | output | 2 | Frame kind: 0 other, 1 ARP, 2 TCP |
| out_pay_off | output | 16 | Byte offset of TCP payload in the frame |

## Verification
The bench places windows across the 2^32 wrap and probes both edges of the sequence and acknowledgment ranges. A design that compared plain magnitudes would reject the in-range frames after the wrap, and an off-by-one bound would accept a segment that ends one byte past the window. Odd-length segments followed by non-zero Ethernet padding check that the checksum stops at the IP length and pads with zero; a checksum that ran to the end of the frame would drop good frames. A 42-byte ARP frame ends mid-header, so a validator that decoded only stored beats rather than the final beat would misjudge it. Fragment flags, an oversize header-length nibble and a truncated frame check the structural rules.

// File: rtl/rxv_pkg.sv
// Shared types and helpers for the receive frame header validator.
package rxv_pkg;

    // Frame kinds reported with the verdict.
    typedef enum logic [1:0] {
        PKT_OTHER = 2'd0,
        PKT_ARP   = 2'd1,
        PKT_TCP   = 2'd2
    } pkt_kind_e;

    // Byte counts of the fixed layout (no VLAN tag, no IP options).
    localparam int unsigned ETH_HDR_BYTES = 14;
    localparam int unsigned IP_HDR_BYTES  = 20;
    // Header bytes the verdict logic decodes (through the TCP flags byte).
    localparam int unsigned HDR_BYTES     = 48;

    // Fold a wide one's-complement accumulator to 16 bits with end-around carry.
    function automatic logic [15:0] fold16(input logic [31:0] s);
        logic [16:0] a;
        a = {1'b0, s[31:16]} + {1'b0, s[15:0]};
        return a[15:0] + {15'd0, a[16]};
    endfunction

endpackage

// File: rtl/rxv_capture.sv
// Beat counter and header store.
// Counts beats within a frame and keeps the first HDR_BEATS beats.
// The header view merges the beat now on the bus, so fields that arrive on
// the final beat are visible in the same cycle.
// Assumes frames are contiguous runs of beats that end with in_last.
module rxv_capture #(
    parameter int DATA_W    = 64,
    parameter int BEAT_W    = 14,
    parameter int HDR_BEATS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_last,
    input  logic [DATA_W-1:0]           in_data,
    output logic [BEAT_W-1:0]           beat_cnt,
    output logic [HDR_BEATS*DATA_W-1:0] hdr_view
);

    // Beat index within the frame, saturating, back to zero after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (in_valid) begin
            if (in_last)          beat_cnt <= '0;
            else if (!(&beat_cnt)) beat_cnt <= beat_cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < HDR_BEATS; k++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        logic              hit;

        assign hit = in_valid && (beat_cnt == BEAT_W'(k));

        // Keep beat k of the current frame.
        always_ff @(posedge clk) begin
            if (!rst_n)   slot_q <= '0;
            else if (hit) slot_q <= in_data;
        end

        // Slot 0 sits at the top of the flat view (frame byte 0 first).
        assign hdr_view[(HDR_BEATS-k)*DATA_W-1 -: DATA_W] = hit ? in_data : slot_q;
    end

endmodule

// File: rtl/rxv_csum.sv
// Streaming one's-complement sums for the IPv4 header and the TCP segment.
// Each byte is masked by its frame position: IPv4 header bytes 14..33 and
// TCP bytes 34..tcp_end-1. A masked-out low byte pads an odd segment end with zero.
// Sums include the beat on the bus so the verdict can use them on the last beat.
// Assumes DATA_W is a multiple of 16 and tcp_end is valid from the third beat.
module rxv_csum #(
    parameter int DATA_W = 64,
    parameter int POS_W  = 17,
    parameter int SUM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic [POS_W-1:0]  beat_pos,
    input  logic [POS_W-1:0]  tcp_end,
    output logic [SUM_W-1:0]  ip_sum,
    output logic [SUM_W-1:0]  tcp_sum
);
    localparam int BYTES = DATA_W / 8;
    localparam int WORDS = BYTES / 2;

    logic [7:0]       ip_b  [BYTES];
    logic [7:0]       tcp_b [BYTES];
    logic [SUM_W-1:0] ip_beat, tcp_beat;
    logic [SUM_W-1:0] ip_acc, tcp_acc;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [POS_W-1:0] pos;
        logic [7:0]       raw;
        assign pos = beat_pos + POS_W'(b);
        assign raw = in_data[DATA_W-1-8*b -: 8];
        // Mask the byte into the IP header sum and the TCP segment sum.
        assign ip_b[b]  = (pos >= POS_W'(14) && pos < POS_W'(34)) ? raw : 8'h00;
        assign tcp_b[b] = (pos >= POS_W'(34) && pos < tcp_end)    ? raw : 8'h00;
    end

    // Add the 16-bit words of this beat.
    always_comb begin
        ip_beat  = '0;
        tcp_beat = '0;
        for (int w = 0; w < WORDS; w++) begin
            ip_beat  = ip_beat  + SUM_W'({ip_b[2*w],  ip_b[2*w+1]});
            tcp_beat = tcp_beat + SUM_W'({tcp_b[2*w], tcp_b[2*w+1]});
        end
    end

    // Accumulate across beats; clear after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_acc  <= '0;
            tcp_acc <= '0;
        end else if (in_valid) begin
            ip_acc  <= in_last ? '0 : ip_acc + ip_beat;
            tcp_acc <= in_last ? '0 : tcp_acc + tcp_beat;
        end
    end

    assign ip_sum  = ip_acc + ip_beat;
    assign tcp_sum = tcp_acc + tcp_beat;

    // The IP region is ten words, so the running sum can never pass ten full words.
    a_r6_ip_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ip_acc <= SUM_W'(10 * 65535));

endmodule

// File: rtl/rxv_window.sv
// Modulo-2^32 range checks for the sequence and acknowledgment numbers.
// Distances are taken by unsigned subtraction, so windows that span the
// wrap point behave like any other.
module rxv_window (
    input  logic [31:0] seq,
    input  logic [31:0] ack,
    input  logic [15:0] pay_len,
    input  logic [31:0] rcv_next,
    input  logic [31:0] rcv_wnd,
    input  logic [31:0] snd_una,
    input  logic [31:0] snd_next,
    output logic        seq_ok,
    output logic        ack_ok
);
    logic [31:0] seq_off;
    logic [32:0] seq_end;
    logic [31:0] ack_off;
    logic [31:0] ack_span;

    // The segment's last byte must stay inside the receive window.
    always_comb begin
        seq_off = seq - rcv_next;
        seq_end = {1'b0, seq_off} + {17'd0, pay_len};
        seq_ok  = seq_end <= {1'b0, rcv_wnd};
    end

    // The acknowledgment must fall inside the sent-but-unacknowledged span.
    always_comb begin
        ack_off  = ack - snd_una;
        ack_span = snd_next - snd_una;
        ack_ok   = ack_off <= ack_span;
    end

endmodule

// File: rtl/rx_hdr_validator.sv
// Receive frame header validator (top).
// Streams one Ethernet frame at a time and registers an accept/reject verdict,
// the frame kind and the TCP payload offset one cycle after the last beat.
// Assumes no VLAN tag, IPv4 without options, big-endian byte order on the bus,
// and in_empty/in_crc_err meaningful only with in_last.
module rx_hdr_validator #(
    parameter  int DATA_W  = 64,
    parameter  int BEAT_W  = 14,
    localparam int BYTES   = DATA_W / 8,
    localparam int EMPTY_W = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_last,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_crc_err,
    input  logic [47:0]        cfg_local_mac,
    input  logic [47:0]        cfg_peer_mac,
    input  logic [31:0]        cfg_local_ip,
    input  logic [31:0]        cfg_peer_ip,
    input  logic [15:0]        cfg_local_port,
    input  logic [15:0]        cfg_peer_port,
    input  logic [31:0]        rcv_next,
    input  logic [31:0]        rcv_wnd,
    input  logic [31:0]        snd_una,
    input  logic [31:0]        snd_next,
    output logic               out_valid,
    output logic               out_accept,
    output logic [1:0]         out_type,
    output logic [15:0]        out_pay_off
);
    import rxv_pkg::*;

    localparam int POS_W     = BEAT_W + EMPTY_W;
    localparam int HDR_BEATS = (HDR_BYTES + BYTES - 1) / BYTES;
    localparam int HV_W      = HDR_BEATS * DATA_W;

    logic [BEAT_W-1:0] beat_cnt;
    logic [HV_W-1:0]   hv;
    logic [7:0]        hb [HDR_BYTES];
    logic [POS_W-1:0]  beat_pos, frame_len, tcp_end;
    logic [31:0]       ip_sum, tcp_sum, tcp_full;
    logic              seq_ok, ack_ok;

    rxv_capture #(.DATA_W(DATA_W), .BEAT_W(BEAT_W), .HDR_BEATS(HDR_BEATS)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .beat_cnt(beat_cnt), .hdr_view(hv)
    );

    for (genvar p = 0; p < HDR_BYTES; p++) begin : g_unpack
        assign hb[p] = hv[HV_W-1-8*p -: 8];
    end

    // Field decode from the header view.
    logic [47:0] eth_dst, eth_src;
    logic [15:0] eth_type, ip_tot, ip_frag, tcp_len, thl_bytes, pay_len;
    logic [31:0] ip_src, ip_dst, tcp_seq, tcp_ack, arp_spa, arp_tpa;
    logic [15:0] sport, dport, arp_htype, arp_ptype, arp_oper;
    logic [3:0]  thl;
    assign eth_dst   = {hb[0], hb[1], hb[2], hb[3], hb[4], hb[5]};
    assign eth_src   = {hb[6], hb[7], hb[8], hb[9], hb[10], hb[11]};
    assign eth_type  = {hb[12], hb[13]};
    assign ip_tot    = {hb[16], hb[17]};
    assign ip_frag   = {hb[20], hb[21]};
    assign ip_src    = {hb[26], hb[27], hb[28], hb[29]};
    assign ip_dst    = {hb[30], hb[31], hb[32], hb[33]};
    assign sport     = {hb[34], hb[35]};
    assign dport     = {hb[36], hb[37]};
    assign tcp_seq   = {hb[38], hb[39], hb[40], hb[41]};
    assign tcp_ack   = {hb[42], hb[43], hb[44], hb[45]};
    assign thl       = hb[46][7:4];
    assign arp_htype = {hb[14], hb[15]};
    assign arp_ptype = {hb[16], hb[17]};
    assign arp_oper  = {hb[20], hb[21]};
    assign arp_spa   = {hb[28], hb[29], hb[30], hb[31]};
    assign arp_tpa   = {hb[38], hb[39], hb[40], hb[41]};
    assign tcp_len   = ip_tot - 16'd20;
    assign thl_bytes = {10'd0, thl, 2'b00};
    assign pay_len   = tcp_len - thl_bytes;

    logic unused_hdr_bits;
    assign unused_hdr_bits = ^{hb[22], hb[24], hb[25], hb[47], hb[46][3:0]};

    // Frame geometry in bytes.
    assign beat_pos  = {beat_cnt, {EMPTY_W{1'b0}}};
    assign frame_len = beat_pos + POS_W'(BYTES) - POS_W'(in_empty);
    assign tcp_end   = POS_W'(ETH_HDR_BYTES) + POS_W'(ip_tot);

    rxv_csum #(.DATA_W(DATA_W), .POS_W(POS_W), .SUM_W(32)) u_csum (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .beat_pos(beat_pos), .tcp_end(tcp_end),
        .ip_sum(ip_sum), .tcp_sum(tcp_sum)
    );

    rxv_window u_win (
        .seq(tcp_seq), .ack(tcp_ack), .pay_len(pay_len),
        .rcv_next(rcv_next), .rcv_wnd(rcv_wnd), .snd_una(snd_una), .snd_next(snd_next),
        .seq_ok(seq_ok), .ack_ok(ack_ok)
    );

    // Add the pseudo-header to the streamed TCP sum.
    assign tcp_full = tcp_sum
                    + {16'd0, ip_src[31:16]} + {16'd0, ip_src[15:0]}
                    + {16'd0, ip_dst[31:16]} + {16'd0, ip_dst[15:0]}
                    + 32'd6 + {16'd0, tcp_len};

    pkt_kind_e kind_c;
    logic      arp_ok, tcp_ok, accept_c;
    logic [15:0] pay_off_c;

    // Classify the frame and evaluate all acceptance rules.
    always_comb begin
        if (eth_type == 16'h0806)                         kind_c = PKT_ARP;
        else if (eth_type == 16'h0800 && hb[23] == 8'd6) kind_c = PKT_TCP;
        else                                              kind_c = PKT_OTHER;

        arp_ok = (arp_htype == 16'd1) && (arp_ptype == 16'h0800)
              && (hb[18] == 8'd6) && (hb[19] == 8'd4)
              && (arp_oper == 16'd1 || arp_oper == 16'd2)
              && (eth_dst == cfg_local_mac || eth_dst == 48'hFFFF_FFFF_FFFF)
              && (arp_spa == cfg_peer_ip) && (arp_tpa == cfg_local_ip)
              && (frame_len >= POS_W'(42));

        tcp_ok = (eth_dst == cfg_local_mac) && (eth_src == cfg_peer_mac)
              && (hb[14] == 8'h45) && !ip_frag[13] && (ip_frag[12:0] == 13'd0)
              && (ip_src == cfg_peer_ip) && (ip_dst == cfg_local_ip)
              && (sport == cfg_peer_port) && (dport == cfg_local_port)
              && (ip_tot >= 16'd40) && (thl >= 4'd5) && (thl_bytes <= tcp_len)
              && (frame_len >= tcp_end)
              && (fold16(ip_sum) == 16'hFFFF) && (fold16(tcp_full) == 16'hFFFF)
              && seq_ok && ack_ok;

        accept_c  = !in_crc_err && ((kind_c == PKT_ARP && arp_ok) || (kind_c == PKT_TCP && tcp_ok));
        pay_off_c = (kind_c == PKT_TCP) ? 16'd34 + thl_bytes : 16'd0;
    end

    // Register the verdict for one cycle after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_accept  <= 1'b0;
            out_type    <= PKT_OTHER;
            out_pay_off <= '0;
        end else begin
            out_valid   <= in_valid && in_last;
            out_accept  <= in_valid && in_last && accept_c;
            out_type    <= (in_valid && in_last) ? kind_c : PKT_OTHER;
            out_pay_off <= (in_valid && in_last) ? pay_off_c : 16'd0;
        end
    end

    // R1: a verdict follows every last beat, and only a last beat.
    a_r1_verdict_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid && in_last)));

    // R1: accept is never raised outside a verdict pulse.
    a_r1_accept_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept |-> out_valid);

    // R10: a frame marked with a check error is never accepted.
    a_r10_crc_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && in_last && in_crc_err)) |-> !out_accept);

    // R11: an accepted TCP frame has its payload 54..94 bytes in, on a 4-byte step from 34.
    a_r11_offset_span: assert property (@(posedge clk) disable iff (!rst_n)
        (out_accept && out_type == PKT_TCP) |->
        (out_pay_off >= 16'd54 && out_pay_off <= 16'd94 && out_pay_off[1:0] == 2'b10));

    // R11: non-TCP verdicts carry no payload offset.
    a_r11_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (out_type != PKT_TCP) |-> (out_pay_off == 16'd0));

endmodule

// File: tb/sim_rx_hdr_validator.sv
module sim_rx_hdr_validator;

    localparam logic [47:0] L_MAC  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] P_MAC  = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [31:0] L_IP   = 32'hC0A8_0A01;
    localparam logic [31:0] P_IP   = 32'hC0A8_0A02;
    localparam logic [15:0] L_PORT = 16'h1F90;
    localparam logic [15:0] P_PORT = 16'hC350;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_empty = '0;
    logic [31:0] rcv_next = 32'h1000, rcv_wnd = 32'h4000;
    logic [31:0] snd_una = 32'h2000, snd_next = 32'h3000;
    logic        out_valid, out_accept;
    logic [1:0]  out_type;
    logic [15:0] out_pay_off;

    always #5 clk = ~clk;

    rx_hdr_validator u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_empty(in_empty), .in_crc_err(in_crc_err),
        .cfg_local_mac(L_MAC), .cfg_peer_mac(P_MAC), .cfg_local_ip(L_IP),
        .cfg_peer_ip(P_IP), .cfg_local_port(L_PORT), .cfg_peer_port(P_PORT),
        .rcv_next(rcv_next), .rcv_wnd(rcv_wnd), .snd_una(snd_una), .snd_next(snd_next),
        .out_valid(out_valid), .out_accept(out_accept), .out_type(out_type),
        .out_pay_off(out_pay_off)
    );

    int checks = 0, errors = 0;
    logic finished = 1'b0;
    logic [7:0] fb [0:255];
    int flen;
    logic got_valid, got_acc, stray;
    logic [1:0] got_type;
    logic [15:0] got_off;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put16(input int p, input logic [15:0] v);
        fb[p] = v[15:8]; fb[p+1] = v[7:0];
    endtask
    task automatic put32(input int p, input logic [31:0] v);
        put16(p, v[31:16]); put16(p+2, v[15:0]);
    endtask
    task automatic put48(input int p, input logic [47:0] v);
        put16(p, v[47:32]); put32(p+2, v[31:0]);
    endtask

    function automatic logic [15:0] ones_sum(input int from, input int to, input logic [31:0] extra);
        logic [31:0] s = extra;
        for (int p = from; p < to; p += 2)
            s += {16'd0, fb[p], (p + 1 < to) ? fb[p+1] : 8'h00};
        s = {16'd0, s[31:16]} + {16'd0, s[15:0]};
        s = {16'd0, s[31:16]} + {16'd0, s[15:0]};
        return s[15:0];
    endfunction

    // Recompute both checksums from the frame bytes (pseudo-header from bytes 26..33).
    task automatic fix_csums();
        logic [15:0] tot, tl;
        logic [31:0] ex;
        tot = {fb[16], fb[17]};
        tl  = tot - 16'd20;
        put16(24, 16'h0);
        put16(24, ~ones_sum(14, 34, 32'd0));
        put16(50, 16'h0);
        ex = {16'd0, fb[26], fb[27]} + {16'd0, fb[28], fb[29]} + {16'd0, fb[30], fb[31]}
           + {16'd0, fb[32], fb[33]} + 32'd6 + {16'd0, tl};
        put16(50, ~ones_sum(34, 14 + int'(tot), ex));
    endtask

    task automatic clear_frame();
        for (int i = 0; i < 256; i++) fb[i] = 8'h00;
    endtask

    task automatic mk_tcp(input logic [31:0] seq, input logic [31:0] ack, input int thl, input int plen);
        int tot;
        clear_frame();
        tot = 20 + thl * 4 + plen;
        put48(0, L_MAC); put48(6, P_MAC); put16(12, 16'h0800);
        fb[14] = 8'h45; put16(16, 16'(tot)); put16(18, 16'h1234); put16(20, 16'h4000);
        fb[22] = 8'd64; fb[23] = 8'd6; put32(26, P_IP); put32(30, L_IP);
        put16(34, P_PORT); put16(36, L_PORT); put32(38, seq); put32(42, ack);
        fb[46] = 8'(thl << 4); fb[47] = 8'h18; put16(48, 16'h2000);
        for (int i = 54; i < 34 + thl * 4; i++) fb[i] = 8'h01;
        for (int i = 0; i < plen; i++) fb[34 + thl * 4 + i] = 8'(i * 7 + 3);
        flen = 14 + tot;
        fix_csums();
    endtask

    task automatic mk_arp(input logic [15:0] oper, input logic [31:0] tpa);
        clear_frame();
        put48(0, 48'hFFFF_FFFF_FFFF); put48(6, P_MAC); put16(12, 16'h0806);
        put16(14, 16'd1); put16(16, 16'h0800); fb[18] = 8'd6; fb[19] = 8'd4;
        put16(20, oper); put48(22, P_MAC); put32(28, P_IP); put32(38, tpa);
        flen = 42;
    endtask

    // Drive the frame in beats at falling edges; sample the verdict one cycle after the last beat.
    task automatic send_frame(input logic crc);
        int nb;
        nb = (flen + 7) / 8;
        stray = 1'b0;
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            if (out_valid) stray = 1'b1;
            in_valid = 1'b1;
            for (int b = 0; b < 8; b++)
                in_data[63-8*b -: 8] = (8*k + b < flen) ? fb[8*k + b] : 8'h00;
            in_last    = (k == nb - 1);
            in_empty   = (k == nb - 1) ? 3'(nb * 8 - flen) : 3'd0;
            in_crc_err = (k == nb - 1) ? crc : 1'b0;
        end
        @(negedge clk);
        got_valid = out_valid; got_acc = out_accept; got_type = out_type; got_off = out_pay_off;
        in_valid = 1'b0; in_last = 1'b0; in_empty = '0; in_crc_err = 1'b0; in_data = '0;
    endtask

    task automatic expect_verdict(input string req, input logic acc, input logic [1:0] typ, input logic [15:0] off);
        chk({req, " verdict pulse"}, {31'd0, got_valid}, 32'd1);
        chk({req, " accept"}, {31'd0, got_acc}, {31'd0, acc});
        chk({req, " kind"}, {30'd0, got_type}, {30'd0, typ});
        chk({req, " payload offset"}, {16'd0, got_off}, {16'd0, off});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset accept", {31'd0, out_accept}, 32'd0);
    endtask

    task automatic t_basic();
        mk_tcp(32'h1000, 32'h2800, 5, 0); send_frame(1'b0);
        expect_verdict("R2 R11 plain TCP", 1'b1, 2'd2, 16'd54);
        chk("R1 no pulse mid-frame", {31'd0, stray}, 32'd0);
        @(negedge clk);
        chk("R1 pulse lasts one cycle", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_options_odd();
        mk_tcp(32'h1000, 32'h2800, 8, 13); send_frame(1'b0);
        expect_verdict("R7 R11 options and odd payload", 1'b1, 2'd2, 16'd66);
        mk_tcp(32'h1000, 32'h2800, 5, 13);
        for (int i = flen; i < flen + 3; i++) fb[i] = 8'hAB;
        flen = flen + 3; send_frame(1'b0);
        expect_verdict("R5 R7 padding ignored", 1'b1, 2'd2, 16'd54);
    endtask

    task automatic t_addr();
        mk_tcp(32'h1000, 32'h2800, 5, 0); put16(36, L_PORT + 16'd1); fix_csums(); send_frame(1'b0);
        chk("R2 wrong local port", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 0); fb[11] = fb[11] ^ 8'h01; send_frame(1'b0);
        chk("R2 wrong peer MAC", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 0); fb[33] = fb[33] ^ 8'h01; fix_csums(); send_frame(1'b0);
        chk("R2 wrong local IP", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 0); fb[35] = fb[35] ^ 8'h01; fix_csums(); send_frame(1'b0);
        chk("R2 wrong peer port", {31'd0, got_acc}, 32'd0);
    endtask

    task automatic t_csum();
        mk_tcp(32'h1000, 32'h2800, 5, 0); fb[25] = fb[25] ^ 8'h01; send_frame(1'b0);
        chk("R6 bad IP checksum", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 8); fb[60] = fb[60] ^ 8'h10; send_frame(1'b0);
        chk("R7 bad TCP checksum", {31'd0, got_acc}, 32'd0);
    endtask

    task automatic t_frag();
        mk_tcp(32'h1000, 32'h2800, 5, 0); put16(20, 16'h2000); fix_csums(); send_frame(1'b0);
        chk("R4 more-fragments set", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 0); put16(20, 16'h0001); fix_csums(); send_frame(1'b0);
        chk("R4 fragment offset nonzero", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 0); put16(20, 16'h0000); fix_csums(); send_frame(1'b0);
        chk("R4 no flags accepted", {31'd0, got_acc}, 32'd1);
        mk_tcp(32'h1000, 32'h2800, 5, 0); fb[14] = 8'h46; fix_csums(); send_frame(1'b0);
        chk("R4 IP header length 24", {31'd0, got_acc}, 32'd0);
    endtask

    task automatic t_thl();
        mk_tcp(32'h1000, 32'h2800, 5, 0); fb[46] = 8'h40; fix_csums(); send_frame(1'b0);
        chk("R5 header length 16", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 15, 0); send_frame(1'b0);
        expect_verdict("R5 R11 header length 60", 1'b1, 2'd2, 16'd94);
        mk_tcp(32'h1000, 32'h2800, 5, 8); fb[46] = 8'h80; fix_csums(); send_frame(1'b0);
        chk("R5 header longer than segment", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 4); flen = flen - 1; send_frame(1'b0);
        chk("R5 truncated frame", {31'd0, got_acc}, 32'd0);
    endtask

    task automatic t_seq();
        rcv_next = 32'hFFFF_FFF0; rcv_wnd = 32'd32;
        mk_tcp(32'hFFFF_FFF8, 32'h2800, 5, 16); send_frame(1'b0);
        chk("R8 inside window across wrap", {31'd0, got_acc}, 32'd1);
        mk_tcp(32'h0000_0000, 32'h2800, 5, 16); send_frame(1'b0);
        chk("R8 ends exactly at window edge", {31'd0, got_acc}, 32'd1);
        mk_tcp(32'h0000_0001, 32'h2800, 5, 16); send_frame(1'b0);
        chk("R8 one byte past window", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'hFFFF_FFE0, 32'h2800, 5, 16); send_frame(1'b0);
        chk("R8 before expected sequence", {31'd0, got_acc}, 32'd0);
        rcv_next = 32'h1000; rcv_wnd = 32'h4000;
    endtask

    task automatic t_ack();
        snd_una = 32'hFFFF_FF00; snd_next = 32'h0000_0100;
        mk_tcp(32'h1000, 32'h0000_0050, 5, 0); send_frame(1'b0);
        chk("R9 ack across wrap", {31'd0, got_acc}, 32'd1);
        mk_tcp(32'h1000, 32'h0000_0100, 5, 0); send_frame(1'b0);
        chk("R9 ack equals next send", {31'd0, got_acc}, 32'd1);
        mk_tcp(32'h1000, 32'h0000_0101, 5, 0); send_frame(1'b0);
        chk("R9 ack beyond next send", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'hFFFF_FF00, 5, 0); send_frame(1'b0);
        chk("R9 ack equals oldest unacked", {31'd0, got_acc}, 32'd1);
        mk_tcp(32'h1000, 32'hFFFF_FEFF, 5, 0); send_frame(1'b0);
        chk("R9 ack below oldest unacked", {31'd0, got_acc}, 32'd0);
        snd_una = 32'h2000; snd_next = 32'h3000;
    endtask

    task automatic t_crc();
        mk_tcp(32'h1000, 32'h2800, 5, 0); send_frame(1'b1);
        chk("R10 check error rejects", {31'd0, got_acc}, 32'd0);
        send_frame(1'b0);
        chk("R10 next frame judged alone", {31'd0, got_acc}, 32'd1);
    endtask

    task automatic t_kinds();
        mk_arp(16'd1, L_IP); send_frame(1'b0);
        expect_verdict("R3 ARP request", 1'b1, 2'd1, 16'd0);
        mk_arp(16'd1, L_IP ^ 32'd1); send_frame(1'b0);
        chk("R3 ARP wrong target IP", {31'd0, got_acc}, 32'd0);
        mk_arp(16'd3, L_IP); send_frame(1'b0);
        chk("R3 ARP bad operation", {31'd0, got_acc}, 32'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 0); put16(12, 16'h86DD); send_frame(1'b0);
        expect_verdict("R3 other EtherType", 1'b0, 2'd0, 16'd0);
        mk_tcp(32'h1000, 32'h2800, 5, 0); fb[23] = 8'd17; fix_csums(); send_frame(1'b0);
        expect_verdict("R3 non-TCP protocol", 1'b0, 2'd0, 16'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_basic();
        t_options_odd();
        t_addr();
        t_csum();
        t_frag();
        t_thl();
        t_seq();
        t_ack();
        t_crc();
        t_kinds();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule